// File: doc/BRIEF.md
# Time-Slot Channel Port

This block joins one device to a shared four-wire serial bus. The bus carries a bit clock with two clock cycles per data bit, a frame sync that marks the start of every frame, a receive wire and a transmit wire. Several devices share the transmit wire as a wired-AND, so a device only ever pulls it low. Each frame is divided into channel slots of 32 bits. A 3-bit strap value picks the slot this device uses.

All bus inputs are resynchronised into the local clock domain. A half-bit counter restarts on every rising frame sync and places the device's slot within the frame. Inside that slot the block sends four bytes, MSB first: B1, B2, Monitor, and a signalling byte made of D, C/I, A and E. It also receives the same four bytes from the receive wire and hands them on together with a one-cycle valid strobe.

The block reads its own transmit wire back. When a bit it released is seen low on the Monitor or C/I field, it raises a sticky clash flag and releases the wire for the rest of that field in the frame. This lets two devices that share one channel back off without corrupting each other.

Top module: `gci_channel_port`

## Requirements
- R1: After reset, bus_pull, rx_valid, mon_clash and ci_clash are all 0.
- R2: A frame sync that is high at a bit-clock rising edge, and was low at the previous rising edge, starts bit 0 of channel 0 at that edge. A later such edge restarts the count at any point, so a slot that has not finished by then produces no rx_valid.
- R3: Channel n occupies frame bits 32*n to 32*n+31, where n is chan_sel. Outside that window bus_pull is 0, and it is released by the first bit boundary after the slot.
- R4: A data bit starts at every second bit-clock rising edge, counted from the frame start. Inside the slot, bus_pull is the inverse of the bit being sent. Slot bit k carries bit 31-k of the word {B1[7:0], B2[7:0], Monitor[7:0], D[1:0], C/I[3:0], A, E}. Slot bits 16..23 form the Monitor field and slot bits 26..29 form the C/I field.
- R5: The transmit inputs are captured at the first bit of the slot. Changes to them later in the slot have no effect on that slot.
- R6: Each received bit is sampled at the second falling bit-clock edge after the bit starts. After bit 31 of the slot is sampled, the rx fields are loaded, in the same packing as R4, together with a single-cycle rx_valid pulse.
- R7: If a Monitor bit the block released (sent as 1) is read back as 0 on bus_sense, mon_clash is set and stays set until reset. The block then releases the wire for the remaining Monitor bits of that slot.
- R8: If a C/I bit the block released is read back as 0, ci_clash is set and stays set until reset. The block then releases the wire for the remaining C/I bits of that slot.
- R9: A released bit read back as 0 in the B1, B2, D, A or E fields sets no flag and does not change the bits sent afterwards.
- R10: Until the first frame sync after reset, bus_pull stays 0 and rx_valid stays 0, whatever the bit clock and data wires do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, much faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_bclk | input | 1 | Bus bit clock, two cycles per data bit |
| bus_fsync | input | 1 | Bus frame sync, rising edge starts the frame |
| bus_rx | input | 1 | Receive data wire |
| bus_sense | input | 1 | Read-back of the wired-AND transmit wire |
| chan_sel | input | 3 | Channel slot strap |
| tx_b1 | input | 8 | B1 byte to send |
| tx_b2 | input | 8 | B2 byte to send |
| tx_mon | input | 8 | Monitor byte to send |
| tx_d | input | 2 | D bits to send |
| tx_ci | input | 4 | C/I bits to send |
| tx_a | input | 1 | A bit to send |
| tx_e | input | 1 | E bit to send |
| bus_pull | output | 1 | Open-drain enable: 1 pulls the transmit wire low |
| rx_b1 | output | 8 | Received B1 byte |
| rx_b2 | output | 8 | Received B2 byte |
| rx_mon | output | 8 | Received Monitor byte |
| rx_d | output | 2 | Received D bits |
| rx_ci | output | 4 | Received C/I bits |
| rx_a | output | 1 | Received A bit |
| rx_e | output | 1 | Received E bit |
| rx_valid | output | 1 | One-cycle strobe when the rx fields are loaded |
| mon_clash | output | 1 | Sticky Monitor contention flag |
| ci_clash | output | 1 | Sticky C/I contention flag |

## Verification
A half-bit counter that is off by one shows up within a single bit period: bus_pull changes at the wrong bit boundary, or the received bytes come out shifted by one position. A wrong slot base moves the whole pull pattern by 32 bits, so the first in-slot or out-of-slot bit is already wrong. A fence that is never raised, or never cleared, shows in the Monitor and C/I bits that follow a forced clash in the same frame, or in the first slot of the next frame. A flag that wrongly ignores a clash, or flags a clash on B1, B2, D, A or E, is visible on the clash outputs right after the slot ends.

// File: rtl/gci_pkg.sv
// Shared constants, field codes and the packed slot word for the
// time-slot channel port. Assumes a 32-bit slot sent MSB first.
package gci_pkg;

    localparam int SLOT_BITS = 32;
    localparam int POS_W     = $clog2(SLOT_BITS);

    // Field that a given slot bit belongs to
    typedef enum logic [2:0] {
        FLD_B1  = 3'd0,
        FLD_B2  = 3'd1,
        FLD_MON = 3'd2,
        FLD_D   = 3'd3,
        FLD_CI  = 3'd4,
        FLD_A   = 3'd5,
        FLD_E   = 3'd6
    } field_e;

    // Slot word; the MSB (b1[7]) is the first bit on the wire
    typedef struct packed {
        logic [7:0] b1;
        logic [7:0] b2;
        logic [7:0] mon;
        logic [1:0] d;
        logic [3:0] ci;
        logic       a;
        logic       e;
    } slot_word_t;

    // Map a bit position inside the slot to its field
    function automatic field_e field_at(input logic [POS_W-1:0] pos);
        if (pos < POS_W'(8))       return FLD_B1;
        else if (pos < POS_W'(16)) return FLD_B2;
        else if (pos < POS_W'(24)) return FLD_MON;
        else if (pos < POS_W'(26)) return FLD_D;
        else if (pos < POS_W'(30)) return FLD_CI;
        else if (pos == POS_W'(30)) return FLD_A;
        else                       return FLD_E;
    endfunction

endpackage

// File: rtl/gci_edge_sync.sv
// Resynchronises the bus wires into the local clock domain.
// Bit 0 of raw is the reference clock: its rising and falling edges are
// reported as one-cycle strobes. The remaining bits are passed through the
// same number of stages, so all wires keep their relative timing.
// Assumes the local clock is at least four times the bus bit clock.
module gci_edge_sync #(
    parameter int NSIG   = 4,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSIG-1:0] raw,
    output logic [NSIG-1:1] data_s,
    output logic            ref_rise,
    output logic            ref_fall
);

    logic [NSIG-1:0] sync_v;
    logic            ref_prev;

    generate
        for (genvar i = 0; i < NSIG; i++) begin : g_sig
            logic [STAGES-1:0] chain;

            // Shift each wire through its own synchroniser chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], raw[i]};
            end

            assign sync_v[i] = chain[STAGES-1];
        end
    endgenerate

    // Remember the last synchronised reference level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) ref_prev <= 1'b0;
        else        ref_prev <= sync_v[0];
    end

    assign ref_rise = sync_v[0] & ~ref_prev;
    assign ref_fall = ~sync_v[0] & ref_prev;
    assign data_s   = sync_v[NSIG-1:1];

endmodule

// File: rtl/gci_slot_timer.sv
// Half-bit counter of the bus frame. Restarts on a rising frame sync seen
// at a bit-clock rising edge, and finds this device's slot from the
// channel strap. It emits a bit-boundary strobe (with slot membership and
// slot position) and a sample strobe at the second falling edge of each
// in-slot bit. Saturates after NUM_SLOTS slots until the next frame sync.
// Assumes NUM_SLOTS >= 2**CH_W.
module gci_slot_timer
    import gci_pkg::*;
#(
    parameter int NUM_SLOTS = 12,
    parameter int CH_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_rise,
    input  logic             bclk_fall,
    input  logic             fsync_s,
    input  logic [CH_W-1:0]  chan,
    output logic             edge_stb,
    output logic             edge_in_slot,
    output logic [POS_W-1:0] edge_pos,
    output logic             smp_stb,
    output logic [POS_W-1:0] smp_pos
);

    localparam int HALF_MAX = 2 * NUM_SLOTS * SLOT_BITS;
    localparam int HC_W     = $clog2(HALF_MAX + 1);

    logic [HC_W-1:0] hcnt;
    logic [HC_W-1:0] hc_next;
    logic [HC_W-1:0] base;
    logic [HC_W-1:0] rel_nx;
    logic [HC_W-1:0] rel_cur;
    logic            fs_prev;
    logic            start;
    logic            framed;

    // Bit offset of this device's slot within the frame
    assign base = HC_W'(chan) << POS_W;

    // Position of a half-bit count relative to the slot base
    function automatic logic [HC_W-1:0] rel_of(input logic [HC_W-1:0] h,
                                               input logic [HC_W-1:0] b);
        return (h >> 1) - b;
    endfunction

    // True when the half-bit count lies in this device's slot
    function automatic logic in_slot(input logic [HC_W-1:0] h,
                                     input logic [HC_W-1:0] b);
        return (rel_of(h, b) < HC_W'(SLOT_BITS)) && (h != HC_W'(HALF_MAX));
    endfunction

    // Next counter value at a bit-clock rising edge
    always_comb begin
        start   = bclk_rise & fsync_s & ~fs_prev;
        if (start)                        hc_next = '0;
        else if (hcnt == HC_W'(HALF_MAX)) hc_next = hcnt;
        else                              hc_next = hcnt + 1'b1;
        rel_nx  = rel_of(hc_next, base);
        rel_cur = rel_of(hcnt, base);
    end

    // Half-bit counter and frame-sync edge tracking, advanced on rising edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt    <= HC_W'(HALF_MAX);
            fs_prev <= 1'b0;
            framed  <= 1'b0;
        end else if (bclk_rise) begin
            hcnt    <= hc_next;
            fs_prev <= fsync_s;
            if (start) framed <= 1'b1;
        end
    end

    // Registered bit-boundary and sample strobes with slot positions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_stb     <= 1'b0;
            edge_in_slot <= 1'b0;
            edge_pos     <= '0;
            smp_stb      <= 1'b0;
            smp_pos      <= '0;
        end else begin
            edge_stb     <= bclk_rise & (framed | start) & ~hc_next[0];
            edge_in_slot <= in_slot(hc_next, base);
            edge_pos     <= rel_nx[POS_W-1:0];
            smp_stb      <= bclk_fall & framed & hcnt[0] & in_slot(hcnt, base);
            smp_pos      <= rel_cur[POS_W-1:0];
        end
    end

    AST_NO_SAMPLE_UNFRAMED: assert property (@(posedge clk) disable iff (!rst_n)
        !framed |=> !smp_stb); // R10

    AST_START_IS_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> edge_stb); // R2

endmodule

// File: rtl/gci_tx_path.sv
// Transmit side of the slot. Captures the transmit word at slot bit 0 and
// drives one bit per bit boundary as an open-drain pull. It reads the
// wire back at each sample point. A released Monitor or C/I bit seen low
// raises a sticky flag and fences that field (wire released) for the rest
// of the slot. Outside the slot the wire is always released.
module gci_tx_path
    import gci_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_stb,
    input  logic             edge_in_slot,
    input  logic [POS_W-1:0] edge_pos,
    input  logic             smp_stb,
    input  logic [POS_W-1:0] smp_pos,
    input  slot_word_t       tx_in,
    input  logic             sense_s,
    output logic             tx_pull,
    output logic             mon_hit,
    output logic             ci_hit
);

    slot_word_t       held;
    logic [31:0]      cur_v;
    logic [POS_W-1:0] idx;
    field_e           lfld;
    field_e           sfld;
    logic             fenced;
    logic             drv_now;
    logic             drv_q;
    logic             kill_mon;
    logic             kill_ci;
    logic             clash;
    logic             slot_first;

    // Select the bit to launch and apply any active field fence
    always_comb begin
        slot_first = edge_stb & edge_in_slot & (edge_pos == '0);
        cur_v      = (edge_pos == '0) ? tx_in : held;
        idx        = POS_W'(SLOT_BITS - 1) - edge_pos;
        lfld       = field_at(edge_pos);
        fenced     = ((lfld == FLD_MON) & kill_mon) | ((lfld == FLD_CI) & kill_ci);
        drv_now    = cur_v[idx] | fenced;
        sfld       = field_at(smp_pos);
        clash      = smp_stb & drv_q & ~sense_s;
    end

    // Launch a bit at each in-slot boundary; release outside the slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held    <= '0;
            drv_q   <= 1'b1;
            tx_pull <= 1'b0;
        end else if (edge_stb) begin
            if (edge_in_slot) begin
                drv_q   <= drv_now;
                tx_pull <= ~drv_now;
                if (edge_pos == '0) held <= tx_in;
            end else begin
                drv_q   <= 1'b1;
                tx_pull <= 1'b0;
            end
        end
    end

    // Per-slot field fences: cleared at slot start, set on a clash
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kill_mon <= 1'b0;
            kill_ci  <= 1'b0;
        end else if (slot_first) begin
            kill_mon <= 1'b0;
            kill_ci  <= 1'b0;
        end else if (clash) begin
            if (sfld == FLD_MON) kill_mon <= 1'b1;
            if (sfld == FLD_CI)  kill_ci  <= 1'b1;
        end
    end

    // Sticky contention flags, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mon_hit <= 1'b0;
            ci_hit  <= 1'b0;
        end else if (clash) begin
            if (sfld == FLD_MON) mon_hit <= 1'b1;
            if (sfld == FLD_CI)  ci_hit  <= 1'b1;
        end
    end

    AST_RELEASE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_stb && !edge_in_slot) |=> !tx_pull); // R3

    AST_MON_FENCE: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_stb && edge_in_slot && kill_mon && lfld == FLD_MON) |=> !tx_pull); // R7

    AST_CI_FENCE: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_stb && edge_in_slot && kill_ci && lfld == FLD_CI) |=> !tx_pull); // R8

    AST_MON_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        mon_hit |=> mon_hit); // R7

    AST_CI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ci_hit |=> ci_hit); // R8

    AST_NO_FLAG_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && sfld != FLD_MON && sfld != FLD_CI && !mon_hit && !ci_hit)
        |=> (!mon_hit && !ci_hit)); // R9

endmodule

// File: rtl/gci_rx_path.sv
// Receive side of the slot. Shifts in one bit per sample strobe and, at
// the last slot bit, loads the full word into the output fields with a
// one-cycle valid strobe. Assumes sample strobes arrive in slot order.
module gci_rx_path
    import gci_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_stb,
    input  logic [POS_W-1:0] smp_pos,
    input  logic             rx_s,
    output slot_word_t       rx_word,
    output logic             rx_valid
);

    logic [SLOT_BITS-2:0] sh;
    logic                 last_bit;

    assign last_bit = smp_stb & (smp_pos == POS_W'(SLOT_BITS - 1));

    // Collect received bits MSB first
    always_ff @(posedge clk) begin
        if (!rst_n)       sh <= '0;
        else if (smp_stb) sh <= {sh[SLOT_BITS-3:0], rx_s};
    end

    // Load the output fields and pulse valid after the last slot bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= last_bit;
            if (last_bit) rx_word <= slot_word_t'({sh, rx_s});
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R6

    AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(smp_stb && smp_pos == POS_W'(SLOT_BITS - 1))); // R6

endmodule

// File: rtl/gci_channel_port.sv
// Time-slot channel port: a slave on a shared four-wire framed bus. It
// resynchronises the bus wires, times the frame and its own slot, sends
// the transmit fields as open-drain pulls and receives the same fields.
// Assumes clk runs at least 4x the bus bit clock and that the bit clock
// gives at least 2**CH_W slots per frame.
module gci_channel_port
    import gci_pkg::*;
#(
    parameter int NUM_SLOTS   = 12,
    parameter int CH_W        = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_bclk,
    input  logic            bus_fsync,
    input  logic            bus_rx,
    input  logic            bus_sense,
    input  logic [CH_W-1:0] chan_sel,
    input  logic [7:0]      tx_b1,
    input  logic [7:0]      tx_b2,
    input  logic [7:0]      tx_mon,
    input  logic [1:0]      tx_d,
    input  logic [3:0]      tx_ci,
    input  logic            tx_a,
    input  logic            tx_e,
    output logic            bus_pull,
    output logic [7:0]      rx_b1,
    output logic [7:0]      rx_b2,
    output logic [7:0]      rx_mon,
    output logic [1:0]      rx_d,
    output logic [3:0]      rx_ci,
    output logic            rx_a,
    output logic            rx_e,
    output logic            rx_valid,
    output logic            mon_clash,
    output logic            ci_clash
);

    localparam int NSIG = 4;

    logic [NSIG-1:1]  wires_s;
    logic             bclk_rise;
    logic             bclk_fall;
    logic             edge_stb;
    logic             edge_in_slot;
    logic [POS_W-1:0] edge_pos;
    logic             smp_stb;
    logic [POS_W-1:0] smp_pos;
    slot_word_t       tx_word;
    slot_word_t       rx_word;

    // Pack the transmit fields into the slot word
    assign tx_word = {tx_b1, tx_b2, tx_mon, tx_d, tx_ci, tx_a, tx_e};

    gci_edge_sync #(
        .NSIG   (NSIG),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw      ({bus_sense, bus_rx, bus_fsync, bus_bclk}),
        .data_s   (wires_s),
        .ref_rise (bclk_rise),
        .ref_fall (bclk_fall)
    );

    gci_slot_timer #(
        .NUM_SLOTS (NUM_SLOTS),
        .CH_W      (CH_W)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .bclk_rise    (bclk_rise),
        .bclk_fall    (bclk_fall),
        .fsync_s      (wires_s[1]),
        .chan         (chan_sel),
        .edge_stb     (edge_stb),
        .edge_in_slot (edge_in_slot),
        .edge_pos     (edge_pos),
        .smp_stb      (smp_stb),
        .smp_pos      (smp_pos)
    );

    gci_tx_path u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .edge_stb     (edge_stb),
        .edge_in_slot (edge_in_slot),
        .edge_pos     (edge_pos),
        .smp_stb      (smp_stb),
        .smp_pos      (smp_pos),
        .tx_in        (tx_word),
        .sense_s      (wires_s[3]),
        .tx_pull      (bus_pull),
        .mon_hit      (mon_clash),
        .ci_hit       (ci_clash)
    );

    gci_rx_path u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_stb  (smp_stb),
        .smp_pos  (smp_pos),
        .rx_s     (wires_s[2]),
        .rx_word  (rx_word),
        .rx_valid (rx_valid)
    );

    // Unpack the received slot word
    assign rx_b1  = rx_word.b1;
    assign rx_b2  = rx_word.b2;
    assign rx_mon = rx_word.mon;
    assign rx_d   = rx_word.d;
    assign rx_ci  = rx_word.ci;
    assign rx_a   = rx_word.a;
    assign rx_e   = rx_word.e;

endmodule

// File: tb/gci_channel_port_test.sv
module gci_channel_port_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_bclk = 1'b0;
    logic       bus_fsync = 1'b0;
    logic       bus_rx = 1'b1;
    logic       oth_pull = 1'b0;
    logic [2:0] chan_sel = '0;
    logic [7:0] tx_b1 = '0, tx_b2 = '0, tx_mon = '0;
    logic [1:0] tx_d = '0;
    logic [3:0] tx_ci = '0;
    logic       tx_a = 1'b0, tx_e = 1'b0;
    logic       bus_pull;
    logic [7:0] rx_b1, rx_b2, rx_mon;
    logic [1:0] rx_d;
    logic [3:0] rx_ci;
    logic       rx_a, rx_e, rx_valid, mon_clash, ci_clash;
    wire        bus_sense = ~(bus_pull | oth_pull);

    int checks = 0;
    int errors = 0;
    int vcount = 0;
    logic exp_m = 1'b0;
    logic exp_c = 1'b0;

    always #4 clk = ~clk;

    gci_channel_port uut (
        .clk(clk), .rst_n(rst_n), .bus_bclk(bus_bclk), .bus_fsync(bus_fsync),
        .bus_rx(bus_rx), .bus_sense(bus_sense), .chan_sel(chan_sel),
        .tx_b1(tx_b1), .tx_b2(tx_b2), .tx_mon(tx_mon), .tx_d(tx_d),
        .tx_ci(tx_ci), .tx_a(tx_a), .tx_e(tx_e), .bus_pull(bus_pull),
        .rx_b1(rx_b1), .rx_b2(rx_b2), .rx_mon(rx_mon), .rx_d(rx_d),
        .rx_ci(rx_ci), .rx_a(rx_a), .rx_e(rx_e), .rx_valid(rx_valid),
        .mon_clash(mon_clash), .ci_clash(ci_clash)
    );

    always @(posedge clk) if (rx_valid) vcount <= vcount + 1;

    task automatic chk(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Field code of slot bit k: 2 = Monitor, 4 = C/I
    function automatic int fld_of(input int k);
        if (k < 8)  return 0;
        if (k < 16) return 1;
        if (k < 24) return 2;
        if (k < 26) return 3;
        if (k < 30) return 4;
        if (k == 30) return 5;
        return 6;
    endfunction

    function automatic logic [31:0] tx_packed();
        return {tx_b1, tx_b2, tx_mon, tx_d, tx_ci, tx_a, tx_e};
    endfunction

    task automatic rand_tx();
        tx_b1 = 8'($urandom); tx_b2 = 8'($urandom); tx_mon = 8'($urandom);
        tx_d = 2'($urandom); tx_ci = 4'($urandom);
        tx_a = 1'($urandom); tx_e = 1'($urandom);
    endtask

    // Expected pulls and flags for nvis slot bits (bit 31-k is slot bit k)
    task automatic build_expect(input logic [31:0] w, input logic [31:0] oth,
                                input int nvis, output logic [31:0] pull,
                                output logic mh, output logic ch);
        logic km = 1'b0, kc = 1'b0;
        mh = 1'b0; ch = 1'b0; pull = '0;
        for (int k = 0; k < nvis; k++) begin
            int f = fld_of(k);
            logic drv = w[31-k] | (f == 2 && km) | (f == 4 && kc);
            pull[31-k] = ~drv;
            if (drv && oth[31-k]) begin
                if (f == 2) begin km = 1'b1; mh = 1'b1; end
                if (f == 4) begin kc = 1'b1; ch = 1'b1; end
            end
        end
    endtask

    // Run one frame of nbits bits with this device on channel ch
    task automatic run_frame(input int ch, input int nbits, input logic [31:0] oth_slot,
                             input logic [31:0] rxw, input bit mid_change,
                             input string note);
        logic [31:0] w0, epull;
        logic mh, chh;
        int base = ch * 32;
        int nvis = nbits - base;
        int bad_in = 0, bad_out = 0, v0;
        logic [31:0] first_act = '0, first_exp = '0;
        bit full;
        if (nvis < 0) nvis = 0;
        if (nvis > 32) nvis = 32;
        full = (nvis == 32);
        chan_sel = 3'(ch);
        w0 = tx_packed();
        build_expect(w0, oth_slot, nvis, epull, mh, chh);
        v0 = vcount;
        for (int b = 0; b < nbits; b++) begin
            int k = b - base;
            bit in_s = (k >= 0 && k < 32);
            if (in_s && mid_change && k == 10) rand_tx();
            bus_rx    = in_s ? rxw[31-k] : 1'($urandom);
            oth_pull  = in_s ? oth_slot[31-k] : ($urandom % 4 == 0);
            bus_fsync = (b == 0);
            bus_bclk  = 1'b1; tick(4);
            bus_bclk  = 1'b0; bus_fsync = 1'b0; tick(4);
            bus_bclk  = 1'b1; tick(3);
            if (in_s) begin
                if (bus_pull !== epull[31-k]) begin
                    if (bad_in == 0) begin first_act = 32'(k); first_exp = 32'(epull[31-k]); end
                    bad_in++;
                end
            end else if (bus_pull !== 1'b0) bad_out++;
            tick(1);
            bus_bclk = 1'b0; tick(4);
        end
        oth_pull = 1'b0;
        tick(6);
        chk(bad_in == 0, {note, " slot pull pattern (first bad slot bit in actual)"},
            first_act, first_exp);
        chk(bad_out == 0, "R3 pull outside slot", 32'(bad_out), 0);
        if (full) begin
            chk(vcount - v0 == 1, "R6 one valid strobe per slot", 32'(vcount - v0), 1);
            chk({rx_b1, rx_b2, rx_mon, rx_d, rx_ci, rx_a, rx_e} == rxw, "R6 received fields",
                {rx_b1, rx_b2, rx_mon, rx_d, rx_ci, rx_a, rx_e}, rxw);
        end else begin
            chk(vcount - v0 == 0, "R2 restart before slot end gives no valid",
                32'(vcount - v0), 0);
        end
        exp_m = exp_m | mh;
        exp_c = exp_c | chh;
        chk(mon_clash == exp_m, {note, " R7 monitor clash flag"}, 32'(mon_clash), 32'(exp_m));
        chk(ci_clash == exp_c, {note, " R8 C/I clash flag"}, 32'(ci_clash), 32'(exp_c));
    endtask

    // Toggle the bit clock with no frame sync
    task automatic idle_bits(input int n);
        int bad = 0, v0 = vcount;
        for (int b = 0; b < n; b++) begin
            bus_rx = 1'($urandom); oth_pull = 1'($urandom);
            bus_bclk = 1'b1; tick(4); bus_bclk = 1'b0; tick(4);
            bus_bclk = 1'b1; tick(3);
            if (bus_pull !== 1'b0) bad++;
            tick(1); bus_bclk = 1'b0; tick(4);
        end
        oth_pull = 1'b0;
        chk(bad == 0, "R10 no pull before first frame sync", 32'(bad), 0);
        chk(vcount == v0, "R10 no valid before first frame sync", 32'(vcount - v0), 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bus_bclk = 1'b0; bus_fsync = 1'b0; oth_pull = 1'b0;
        tick(6);
        rst_n = 1'b1;
        exp_m = 1'b0; exp_c = 1'b0;
        tick(2);
        chk(bus_pull == 1'b0 && rx_valid == 1'b0, "R1 outputs idle after reset",
            {30'b0, bus_pull, rx_valid}, 0);
        chk(mon_clash == 1'b0 && ci_clash == 1'b0, "R1 flags clear after reset",
            {30'b0, mon_clash, ci_clash}, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog expired actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0013));
        do_reset();
        idle_bits(20);

        // Channel 0, fixed pattern (R2 start, R4 packing)
        tx_b1 = 8'hA5; tx_b2 = 8'h3C; tx_mon = 8'h96; tx_d = 2'b10;
        tx_ci = 4'b0110; tx_a = 1'b0; tx_e = 1'b1;
        run_frame(0, 36, 32'h0, 32'h1234_5678, 1'b0, "R4");

        // Highest channel
        rand_tx();
        run_frame(7, 7*32+34, 32'h0, 32'hC0FF_EE11, 1'b0, "R4");

        // Transmit inputs change mid-slot
        rand_tx();
        run_frame(2, 2*32+35, 32'h0, 32'h0F0F_A5A5, 1'b1, "R5");

        // Contention only on B1, B2, D, A, E while released
        tx_b1 = 8'hFF; tx_b2 = 8'hFF; tx_mon = 8'h5A; tx_d = 2'b11;
        tx_ci = 4'b1001; tx_a = 1'b1; tx_e = 1'b1;
        run_frame(3, 3*32+34, 32'hFFFF_00C3, 32'h8001_7FFE, 1'b0, "R9");

        // Restart before the slot is reached
        rand_tx();
        run_frame(5, 100, 32'h0, 32'h0, 1'b0, "R2");

        // Monitor clash at slot bit 18, then fence the rest of Monitor
        rand_tx(); tx_mon = 8'hE0;
        run_frame(1, 1*32+36, 32'h0000_2000, 32'h2468_ACE0, 1'b0, "R7");

        // C/I clash at slot bit 27, then fence the rest of C/I
        rand_tx(); tx_ci = 4'b1100;
        run_frame(4, 4*32+36, 32'h0000_0010, 32'h1357_9BDF, 1'b0, "R8");

        // Reset clears sticky flags and framing
        do_reset();
        idle_bits(8);

        // Random frames, some cut short inside the slot
        for (int i = 0; i < 14; i++) begin
            int ch = $urandom % 8;
            int nb = ch * 32 + 33 + ($urandom % 4);
            logic [31:0] oth = '0;
            if (i % 5 == 4) nb = ch * 32 + 1 + ($urandom % 30);
            for (int k = 0; k < 32; k++) oth[k] = ($urandom % 10 == 0);
            rand_tx();
            run_frame(ch, nb, oth, $urandom, (i % 3 == 0), "R4");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule